// File: doc/BRIEF.md
# Stack-Frame Interrupt Context Sequencer

This block saves and restores processor context on the system stack for a small core that has no banked registers and no dedicated return-address or status holding registers. When the core takes an interrupt, the sequencer stores the status word, the return address and the five general registers R8 to R12 in memory, one word per beat. It moves the stack pointer it owns down by one word before each store. When the handler ends, the sequencer runs the same frame backwards. It reads each word at the stack pointer, moves the pointer up, and hands the register words back to the register file. The status word and the return address appear on the resume outputs.

Exceptions and system calls use a shorter frame that holds only the status word and the return address. Their return reads those two words back. Each command arrives on a valid/ready request channel. The register file is reached through a second valid/ready channel. Memory uses a request line plus a wait line that stretches the current beat.

The request channel has these back-pressure rules. `req_ready` is high only while the sequencer is idle. A command is taken on a clock edge where both `req_valid` and `req_ready` are high. A register-file beat completes on an edge where `rf_valid` and `rf_ready` are both high. A memory beat completes on an edge where `mem_valid` is high and `mem_wait` is low. Until a beat completes, its outputs hold steady.

Top module: `ctxsv_top`

## Requirements
- R1: `req_ready` is high exactly when the block is idle, and a command is accepted on an edge where `req_valid` and `req_ready` are both high. The command codes are: 0 interrupt entry, 1 interrupt return, 2 exception or system-call entry, 3 exception or system-call return.
- R2: An interrupt entry (code 0) stores seven words in this order: status, return address, R12, R11, R10, R9, R8. It makes the same frame for every interrupt. Each register value is fetched with a register-file read beat (`rf_we` low, `rf_idx` holding the register number), so five read beats are made.
- R3: An exception or system-call entry (code 2) stores only the status word and then the return address, and makes no register-file beat.
- R4: Every store writes to address `sp - 4`, and `sp` drops by 4 on the edge where that store completes.
- R5: Every load reads from address `sp`, and `sp` rises by 4 on the edge where that load completes. An interrupt return (code 1) loads R8, R9, R10, R11, R12, the return address and then the status word. It writes each register back with a register-file write beat. An exception return (code 3) loads the return address and then the status word, with no register-file beat.
- R6: While `mem_wait` is high during a memory beat, the beat's address and data hold, and `sp` does not change. While `rf_ready` is low, the register-file beat holds.
- R7: `busy` is high from the edge that accepts a command until the edge that completes its last beat. `done` is a single-cycle pulse in the cycle after that edge, and `busy` is low during that cycle.
- R8: After a return sequence, `resume_pc` and `resume_status` hold the return address and status word that were loaded from the stack.
- R9: After reset, `sp` equals `SP_RESET` (0x1000 by default), `busy`, `done`, `mem_valid` and `rf_valid` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Command present |
| req_ready | output | 1 | Block idle, able to take a command |
| req_kind | input | 2 | Command code (see R1) |
| req_ret_addr | input | DATA_W | Return address to save on entry |
| req_status | input | DATA_W | Status word to save on entry |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| resume_pc | output | DATA_W | Return address loaded on a return |
| resume_status | output | DATA_W | Status word loaded on a return |
| rf_valid | output | 1 | Register-file beat request |
| rf_ready | input | 1 | Register file completes the beat |
| rf_we | output | 1 | Register-file write (1) or read (0) |
| rf_idx | output | IDX_W | Register number |
| rf_wdata | output | DATA_W | Register write data |
| rf_rdata | input | DATA_W | Register read data, valid while rf_ready |
| mem_valid | output | 1 | Memory beat request |
| mem_wait | input | 1 | Memory stalls the current beat |
| mem_we | output | 1 | Memory store (1) or load (0) |
| mem_addr | output | ADDR_W | Byte address of the beat |
| mem_wdata | output | DATA_W | Store data |
| mem_rdata | input | DATA_W | Load data, valid while mem_wait is low |
| sp | output | ADDR_W | Current stack pointer |

## Verification
The assertions assume that `mem_wait` and `rf_ready` change only between clock edges, and that memory and the register file finish every beat after a bounded stall. They also assume that a return command only follows a matching entry, so the frame it reads back is the frame that was stored. The bench drives the stall lines at the falling edge from a repeating pattern that lets a beat through at least every third cycle. It issues commands only while the block is idle and always pairs each return with the entry of the same kind.

// File: rtl/ctxsv_pkg.sv
package ctxsv_pkg;
  typedef enum logic [1:0] {
    REQ_IRQ_ENTER = 2'd0,
    REQ_IRQ_LEAVE = 2'd1,
    REQ_EXC_ENTER = 2'd2,
    REQ_EXC_LEAVE = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    ITEM_STATUS  = 2'd0,
    ITEM_RETADDR = 2'd1,
    ITEM_GPR     = 2'd2
  } item_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RF_RD  = 3'd1,
    ST_MEM_WR = 3'd2,
    ST_MEM_RD = 3'd3,
    ST_RF_WR  = 3'd4
  } state_e;
endpackage

// File: rtl/ctxsv_order.sv
module ctxsv_order
  import ctxsv_pkg::*;
#(
  parameter int NUM_SAVED   = 5,
  parameter int FIRST_SAVED = 8,
  parameter int IDX_W       = 4,
  parameter int CNT_W       = 3
) (
  input  logic             is_push,
  input  logic [CNT_W-1:0] frame_len,
  input  logic [CNT_W-1:0] pos,
  output item_e            item,
  output logic [IDX_W-1:0] reg_idx,
  output logic             last
);
  localparam int TOP_PLUS = FIRST_SAVED + NUM_SAVED + 1;

  logic [CNT_W-1:0] k;

  always_comb begin
    k       = is_push ? pos : (frame_len - CNT_W'(1) - pos);
    last    = (pos == frame_len - CNT_W'(1));
    reg_idx = IDX_W'(TOP_PLUS) - IDX_W'(k);
    if (k == '0)              item = ITEM_STATUS;
    else if (k == CNT_W'(1))  item = ITEM_RETADDR;
    else                      item = ITEM_GPR;
  end
endmodule

// File: rtl/ctxsv_sp.sv
module ctxsv_sp #(
  parameter int          ADDR_W   = 32,
  parameter logic [31:0] SP_RESET = 32'h0000_1000,
  parameter int          STEP     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec,
  input  logic              inc,
  output logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] sp_minus
);
  assign sp_minus = sp - ADDR_W'(STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sp <= ADDR_W'(SP_RESET);
    else if (dec) sp <= sp_minus;
    else if (inc) sp <= sp + ADDR_W'(STEP);
  end
endmodule

// File: rtl/ctxsv_stage.sv
module ctxsv_stage #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_entry,
  input  logic [DATA_W-1:0] entry_status,
  input  logic [DATA_W-1:0] entry_ra,
  input  logic              ld_word,
  input  logic [DATA_W-1:0] word_d,
  input  logic              ld_pc,
  input  logic              ld_status,
  input  logic [DATA_W-1:0] pop_d,
  output logic [DATA_W-1:0] saved_status,
  output logic [DATA_W-1:0] saved_ra,
  output logic [DATA_W-1:0] word_q,
  output logic [DATA_W-1:0] resume_pc,
  output logic [DATA_W-1:0] resume_status
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      saved_status  <= '0;
      saved_ra      <= '0;
      word_q        <= '0;
      resume_pc     <= '0;
      resume_status <= '0;
    end else begin
      if (ld_entry) begin
        saved_status <= entry_status;
        saved_ra     <= entry_ra;
      end
      if (ld_word)   word_q        <= word_d;
      if (ld_pc)     resume_pc     <= pop_d;
      if (ld_status) resume_status <= pop_d;
    end
  end
endmodule

// File: rtl/ctxsv_top.sv
module ctxsv_top
  import ctxsv_pkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter int          ADDR_W      = 32,
  parameter int          IDX_W       = 4,
  parameter int          NUM_SAVED   = 5,
  parameter int          FIRST_SAVED = 8,
  parameter int          WORD_BYTES  = 4,
  parameter logic [31:0] SP_RESET    = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [DATA_W-1:0] req_ret_addr,
  input  logic [DATA_W-1:0] req_status,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] resume_pc,
  output logic [DATA_W-1:0] resume_status,
  output logic              rf_valid,
  input  logic              rf_ready,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_idx,
  output logic [DATA_W-1:0] rf_wdata,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              mem_valid,
  input  logic              mem_wait,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] sp
);
  localparam int IRQ_FRAME = NUM_SAVED + 2;
  localparam int EXC_FRAME = 2;
  localparam int CNT_W     = $clog2(IRQ_FRAME + 1);

  state_e           state, state_d;
  logic             is_push;
  logic [CNT_W-1:0] frame_len;
  logic [CNT_W-1:0] cnt;
  item_e            cur_item;
  logic             cur_last;
  logic [ADDR_W-1:0] sp_minus;
  logic [DATA_W-1:0] saved_status, saved_ra, word_q;
  logic             accept;
  logic             wr_done, rd_done, rfw_done, rfr_done;
  logic             beat_end;
  logic             sp_dec, sp_inc;
  logic             ld_word;
  logic [DATA_W-1:0] word_d;

  ctxsv_order #(
    .NUM_SAVED(NUM_SAVED), .FIRST_SAVED(FIRST_SAVED),
    .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_order (
    .is_push(is_push), .frame_len(frame_len), .pos(cnt),
    .item(cur_item), .reg_idx(rf_idx), .last(cur_last)
  );

  ctxsv_sp #(.ADDR_W(ADDR_W), .SP_RESET(SP_RESET), .STEP(WORD_BYTES)) u_sp (
    .clk(clk), .rst_n(rst_n), .dec(sp_dec), .inc(sp_inc),
    .sp(sp), .sp_minus(sp_minus)
  );

  ctxsv_stage #(.DATA_W(DATA_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .ld_entry(accept), .entry_status(req_status), .entry_ra(req_ret_addr),
    .ld_word(ld_word), .word_d(word_d),
    .ld_pc(rd_done && cur_item == ITEM_RETADDR),
    .ld_status(rd_done && cur_item == ITEM_STATUS),
    .pop_d(mem_rdata),
    .saved_status(saved_status), .saved_ra(saved_ra), .word_q(word_q),
    .resume_pc(resume_pc), .resume_status(resume_status)
  );

  // Port drive
  assign req_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign mem_valid = (state == ST_MEM_WR) || (state == ST_MEM_RD);
  assign mem_we    = (state == ST_MEM_WR);
  assign mem_addr  = mem_we ? sp_minus : sp;
  assign rf_valid  = (state == ST_RF_RD) || (state == ST_RF_WR);
  assign rf_we     = (state == ST_RF_WR);
  assign rf_wdata  = word_q;

  always_comb begin
    case (cur_item)
      ITEM_STATUS:  mem_wdata = saved_status;
      ITEM_RETADDR: mem_wdata = saved_ra;
      default:      mem_wdata = word_q;
    endcase
  end

  // Beat completion
  assign wr_done  = (state == ST_MEM_WR) && !mem_wait;
  assign rd_done  = (state == ST_MEM_RD) && !mem_wait;
  assign rfr_done = (state == ST_RF_RD) && rf_ready;
  assign rfw_done = (state == ST_RF_WR) && rf_ready;
  assign sp_dec   = wr_done;
  assign sp_inc   = rd_done;
  assign beat_end = wr_done || rfw_done || (rd_done && cur_item != ITEM_GPR);
  assign ld_word  = rfr_done || (rd_done && cur_item == ITEM_GPR);
  assign word_d   = rfr_done ? rf_rdata : mem_rdata;

  always_comb begin
    state_d = state;
    case (state)
      ST_IDLE:
        if (accept) state_d = req_kind[0] ? ST_MEM_RD : ST_MEM_WR;
      ST_RF_RD:
        if (rfr_done) state_d = ST_MEM_WR;
      ST_MEM_RD:
        if (rd_done && cur_item == ITEM_GPR) state_d = ST_RF_WR;
      default: ;
    endcase
    if (beat_end) begin
      if (cur_last)      state_d = ST_IDLE;
      else if (!is_push) state_d = ST_MEM_RD;
      else if (cnt >= CNT_W'(1)) state_d = ST_RF_RD;
      else               state_d = ST_MEM_WR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      is_push   <= 1'b0;
      frame_len <= CNT_W'(EXC_FRAME);
      cnt       <= '0;
      done      <= 1'b0;
    end else begin
      state <= state_d;
      done  <= beat_end && cur_last;
      if (accept) begin
        is_push   <= !req_kind[0];
        frame_len <= req_kind[1] ? CNT_W'(EXC_FRAME) : CNT_W'(IRQ_FRAME);
        cnt       <= '0;
      end else if (beat_end) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/ctxsv_checker.sv
module ctxsv_checker #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 4,
  parameter int WORD_BYTES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_kind,
  input logic [DATA_W-1:0] req_ret_addr,
  input logic [DATA_W-1:0] req_status,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] resume_pc,
  input logic [DATA_W-1:0] resume_status,
  input logic              rf_valid,
  input logic              rf_ready,
  input logic              rf_we,
  input logic [IDX_W-1:0]  rf_idx,
  input logic [DATA_W-1:0] rf_wdata,
  input logic [DATA_W-1:0] rf_rdata,
  input logic              mem_valid,
  input logic              mem_wait,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [DATA_W-1:0] mem_rdata,
  input logic [ADDR_W-1:0] sp
);
  // R1: a command is taken only from idle
  p_accept_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  // R4: store address and pre-decrement
  p_push_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we) |-> (mem_addr == sp - ADDR_W'(WORD_BYTES)));
  p_push_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we && !mem_wait) |=> (sp == $past(sp) - ADDR_W'(WORD_BYTES)));

  // R5: load address and post-increment
  p_pop_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_we) |-> (mem_addr == sp));
  p_pop_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_we && !mem_wait) |=> (sp == $past(sp) + ADDR_W'(WORD_BYTES)));

  // R6: a stalled beat holds and sp stays
  p_stall_sp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_wait) |=> $stable(sp));
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_wait) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata)));
  p_rf_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_valid && !rf_ready) |=> (rf_valid && $stable(rf_idx) && $stable(rf_we)));

  // R7: done is a lone pulse while not busy
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !mem_valid && !rf_valid));
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // One port at a time
  p_one_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_valid && rf_valid));
endmodule

bind ctxsv_top ctxsv_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .WORD_BYTES(WORD_BYTES)
) u_chk (.*);

// File: tb/tb_ctxsv_top.sv
module tb_ctxsv_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = 2'd0;
  logic [31:0] req_ret_addr = '0;
  logic [31:0] req_status = '0;
  logic        busy, done;
  logic [31:0] resume_pc, resume_status;
  logic        rf_valid, rf_we;
  logic        rf_ready = 1'b1;
  logic [3:0]  rf_idx;
  logic [31:0] rf_wdata, rf_rdata;
  logic        mem_valid, mem_we;
  logic        mem_wait = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, sp;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit stall_en = 1'b0;
  int stall_bad = 0;
  bit prev_stall = 1'b0;
  logic [31:0] prev_sp = '0;

  logic [31:0] mem [1024];
  logic [31:0] rf [16];
  int          log_n = 0;
  int          rf_n = 0;
  logic        log_we [16];
  logic [31:0] log_addr [16];
  logic [31:0] log_data [16];

  always #10 clk = ~clk;

  ctxsv_top dut (.*);

  assign rf_rdata  = rf[rf_idx];
  assign mem_rdata = mem[mem_addr[11:2]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_valid && !mem_wait) begin
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      if (log_n < 16) begin
        log_we[log_n]   <= mem_we;
        log_addr[log_n] <= mem_addr;
        log_data[log_n] <= mem_we ? mem_wdata : mem_rdata;
      end
      log_n <= log_n + 1;
    end
    if (rf_valid && rf_ready) begin
      if (rf_we) rf[rf_idx] <= rf_wdata;
      rf_n <= rf_n + 1;
    end
  end

  always @(negedge clk) begin
    if (prev_stall && sp !== prev_sp) stall_bad = stall_bad + 1;
    mem_wait = stall_en && ((cyc % 3) != 0);
    rf_ready = !stall_en || ((cyc % 2) == 0);
    prev_stall = mem_valid && mem_wait;
    prev_sp = sp;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic logic [31:0] regval(input int r, input int seed);
    return 32'hA500_0000 + (seed << 8) + r;
  endfunction

  task automatic run_cmd(input logic [1:0] kind, input logic [31:0] ra, input logic [31:0] st);
    int n;
    log_n = 0;
    rf_n = 0;
    @(negedge clk);
    check("R1 ready while idle", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_kind = kind; req_ret_addr = ra; req_status = st;
    @(negedge clk);
    req_valid = 1'b0;
    check("R7 busy after accept", {31'd0, busy}, 32'd1);
    check("R1 not ready while busy", {31'd0, req_ready}, 32'd0);
    n = 0;
    while (!done && n < 500) begin
      @(negedge clk);
      n++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL R7: done never seen, actual 0 expected 1");
      report();
    end
    check("R7 busy low with done", {31'd0, busy}, 32'd0);
    @(negedge clk);
    check("R7 done lasts one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 sp reset", sp, 32'h0000_1000);
    check("R9 busy reset", {31'd0, busy}, 32'd0);
    check("R9 done reset", {31'd0, done}, 32'd0);
    check("R9 ready reset", {31'd0, req_ready}, 32'd1);
    check("R9 ports idle", {30'd0, mem_valid, rf_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_irq_entry(input int seed, input logic [31:0] ra, input logic [31:0] st);
    for (int r = 8; r <= 12; r++) rf[r] = regval(r, seed);
    run_cmd(2'd0, ra, st);
    check("R2 seven stores", log_n, 32'd7);
    check("R2 five register reads", rf_n, 32'd5);
    for (int i = 0; i < 7; i++) begin
      logic [31:0] ed;
      ed = (i == 0) ? st : (i == 1) ? ra : regval(12 - (i - 2), seed);
      check("R2 store is a write", {31'd0, log_we[i]}, 32'd1);
      check("R2 store data order", log_data[i], ed);
      check("R4 store address", log_addr[i], 32'h1000 - 32'(4 * (i + 1)));
    end
    check("R4 sp after frame", sp, 32'h0000_0FE4);
  endtask

  task automatic t_irq_return(input int seed, input logic [31:0] ra, input logic [31:0] st);
    for (int r = 8; r <= 12; r++) rf[r] = 32'h0;
    run_cmd(2'd1, 32'hDEAD_0000, 32'hDEAD_0001);
    check("R5 seven loads", log_n, 32'd7);
    check("R5 five register writes", rf_n, 32'd5);
    for (int p = 0; p < 7; p++) begin
      logic [31:0] ed;
      ed = (p < 5) ? regval(8 + p, seed) : (p == 5) ? ra : st;
      check("R5 load is a read", {31'd0, log_we[p]}, 32'd0);
      check("R5 load address", log_addr[p], 32'h0FE4 + 32'(4 * p));
      check("R5 load data order", log_data[p], ed);
    end
    for (int r = 8; r <= 12; r++) check("R5 register restored", rf[r], regval(r, seed));
    check("R5 sp restored", sp, 32'h0000_1000);
    check("R8 resume pc", resume_pc, ra);
    check("R8 resume status", resume_status, st);
  endtask

  task automatic t_exc(input logic [31:0] ra, input logic [31:0] st);
    run_cmd(2'd2, ra, st);
    check("R3 two stores", log_n, 32'd2);
    check("R3 no register beat", rf_n, 32'd0);
    check("R3 first is status", log_data[0], st);
    check("R3 second is return address", log_data[1], ra);
    check("R4 exception store address", log_addr[1], 32'h0000_0FF8);
    check("R4 sp after short frame", sp, 32'h0000_0FF8);
    run_cmd(2'd3, 32'h0, 32'h0);
    check("R5 two loads", log_n, 32'd2);
    check("R5 no register beat on return", rf_n, 32'd0);
    check("R5 first load is return address", log_data[0], ra);
    check("R5 second load address", log_addr[1], 32'h0000_0FFC);
    check("R5 sp after short return", sp, 32'h0000_1000);
    check("R8 exception resume pc", resume_pc, ra);
    check("R8 exception resume status", resume_status, st);
  endtask

  task automatic t_stall();
    stall_en = 1'b1;
    stall_bad = 0;
    t_irq_entry(7, 32'h0000_4440, 32'h0001_00C3);
    t_irq_return(7, 32'h0000_4440, 32'h0001_00C3);
    t_exc(32'h0000_5550, 32'h0000_0021);
    stall_en = 1'b0;
    check("R6 sp stable over stalled beats", stall_bad, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    for (int i = 0; i < 16; i++) rf[i] = '0;
    t_reset();
    t_irq_entry(1, 32'h0000_2000, 32'h0040_0001);
    t_irq_return(1, 32'h0000_2000, 32'h0040_0001);
    t_irq_entry(2, 32'h0000_3004, 32'h00C0_0002);
    t_irq_return(2, 32'h0000_3004, 32'h00C0_0002);
    t_exc(32'h0000_1230, 32'h0000_0010);
    t_stall();
    report();
  end

  initial begin
    #(20 * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule